// File: doc/BRIEF.md
# Command Submission and Completion Tracker

This block is the front end of a per-core command dispatcher. A control processor hands it commands through a valid/ready port. The block takes a free tag from an eight-entry inflight table for each accepted command and keeps the command in a submission FIFO. It then turns each command into one sub-command on the queue port of the engine that the command names. The engines are a DMA engine, a GEMM engine, a MATH engine, and a tiled-pipeline sequencer that counts as one more engine. The processor has no path to the engine queues. Its only path is the submission port.

Engines report a finished sub-command with a completion event that carries the tag. Only the tracker changes an entry's state. When several events arrive in the same cycle, it accepts the one from the lowest engine index. It moves the accepted event into a staging register. From there a completion record (tag and engine) goes into a completion FIFO. The table entry is released, and the tag can be reused, only in the cycle that the FIFO accepts the record. Three event strobes (submitted, dispatched, complete) report each step, and each strobe carries its tag. The strobes follow directly from the port activity, so identical input sequences give identical traces.

Top module: `cmd_tracker`

## Requirements
- R1: While reset is active and in the first cycle after it, `sub_ready` is 1, and `eng_valid`, `cmp_ready`, `cq_valid` and all three event strobes are 0.
- R2: An accepted command (`sub_valid` and `sub_ready` both high) receives the lowest-numbered free tag. In the same cycle `ev_submit` is 1 and `ev_submit_tag` gives that tag.
- R3: Command kind encoding: 0 is DMA, 1 is GEMM, 2 is MATH and 3 is composite. A command of kind k is offered only on `eng_valid[k]`, with its tag and payload. If the submission FIFO is empty, the offer comes the cycle after acceptance. `ev_dispatch` pulses in the cycle the engine takes it.
- R4: Sub-commands leave in submission order. While the oldest command's engine is not ready, no later command is offered to any engine.
- R5: With all eight tags in use, `sub_ready` is 0.
- R6: When several `cmp_valid` bits are high, `cmp_ready` has exactly one bit set, and that bit is the lowest index among them.
- R7: An event accepted at one clock edge is pushed into the completion FIFO during the next cycle when there is room. In that cycle `ev_complete` and `ev_complete_tag` report it. The record then appears on `cq_tag`/`cq_eng` in FIFO order, and the tag is free for reuse after that edge.
- R8: While the completion FIFO is full, the staged record is kept, `cmp_ready` stays 0, and its tag remains occupied: no new command receives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_valid | input | 1 | Command offered by the control processor |
| sub_ready | output | 1 | A free tag exists and the submission FIFO has room |
| sub_kind | input | 2 | Command kind (0 DMA, 1 GEMM, 2 MATH, 3 composite) |
| sub_payload | input | PAY_W | Opaque command operand |
| eng_valid | output | 4 | Sub-command offered to engine queue i |
| eng_ready | input | 4 | Engine queue i can take a sub-command |
| eng_tag | output | TAG_W | Tag of the offered sub-command |
| eng_payload | output | PAY_W | Operand of the offered sub-command |
| cmp_valid | input | 4 | Engine i reports a finished sub-command |
| cmp_tag | input | 4*TAG_W | Finished tag per engine, engine i at bits i*TAG_W upward |
| cmp_ready | output | 4 | Completion event of engine i accepted |
| cq_valid | output | 1 | Completion record available |
| cq_ready | input | 1 | Consumer takes the completion record |
| cq_tag | output | TAG_W | Tag of the completed command |
| cq_eng | output | 2 | Engine that executed it |
| ev_submit | output | 1 | Command-submitted strobe |
| ev_submit_tag | output | TAG_W | Tag of the submitted command |
| ev_dispatch | output | 1 | Sub-command-dispatched strobe |
| ev_dispatch_tag | output | TAG_W | Tag of the dispatched sub-command |
| ev_complete | output | 1 | Command-complete strobe |
| ev_complete_tag | output | TAG_W | Tag of the completed command |

## Verification
The checks assume that each engine reports completion only for a tag that was dispatched to it and is still unfinished, and that it reports that tag exactly once. They also assume that each engine holds an event until `cmp_ready` accepts it. The bench engine model reports only tags it saw go out on its own queue port. It lowers each valid bit in the cycle after that event is taken, and it never completes a tag twice. Stimulus changes only on the falling clock edge, so every handshake is settled when the rising edge samples it.

// File: rtl/cmd_trk_pkg.sv
package cmd_trk_pkg;

  localparam int NUM_ENG = 4;
  localparam int ENG_W   = 2;

  typedef enum logic [ENG_W-1:0] {
    ENG_DMA  = 2'd0,
    ENG_GEMM = 2'd1,
    ENG_MATH = 2'd2,
    ENG_SEQ  = 2'd3
  } eng_e;

  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_QUEUED = 2'd1,
    ST_ISSUED = 2'd2,
    ST_DONE   = 2'd3
  } ent_st_e;

endpackage

// File: rtl/cmd_trk_fifo.sv
module cmd_trk_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         nonempty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign dout     = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + AW'(1);
    if (pop)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + AW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= din;
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);

endmodule

// File: rtl/cmd_trk_table.sv
module cmd_trk_table
  import cmd_trk_pkg::*;
#(
  parameter int NUM_TAGS = 8,
  parameter int TAG_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [ENG_W-1:0] alloc_eng,
  output logic             free_any,
  output logic [TAG_W-1:0] free_tag,
  input  logic             issue_en,
  input  logic [TAG_W-1:0] issue_tag,
  input  logic             done_en,
  input  logic [TAG_W-1:0] done_tag,
  input  logic [ENG_W-1:0] done_eng,
  input  logic             rel_en,
  input  logic [TAG_W-1:0] rel_tag
);

  ent_st_e          st_q  [NUM_TAGS];
  ent_st_e          st_d  [NUM_TAGS];
  logic [ENG_W-1:0] eng_q [NUM_TAGS];
  logic [ENG_W-1:0] eng_d [NUM_TAGS];

  always_comb begin
    free_any = 1'b0;
    free_tag = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (st_q[i] == ST_FREE) begin
        free_any = 1'b1;
        free_tag = TAG_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_TAGS; i++) begin
      st_d[i]  = st_q[i];
      eng_d[i] = eng_q[i];
    end
    if (alloc_en) begin
      st_d[free_tag]  = ST_QUEUED;
      eng_d[free_tag] = alloc_eng;
    end
    if (issue_en) st_d[issue_tag] = ST_ISSUED;
    if (done_en)  st_d[done_tag]  = ST_DONE;
    if (rel_en)   st_d[rel_tag]   = ST_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        st_q[i]  <= ST_FREE;
        eng_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        st_q[i]  <= st_d[i];
        eng_q[i] <= eng_d[i];
      end
    end
  end

  // R2
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (free_any && st_q[free_tag] == ST_FREE));

  // R4
  issue_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> (st_q[issue_tag] == ST_QUEUED));

  // R7
  done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_en |-> (st_q[done_tag] == ST_ISSUED && eng_q[done_tag] == done_eng));

  // R8
  release_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> (st_q[rel_tag] == ST_DONE));

endmodule

// File: rtl/cmd_trk_cmp_arb.sv
module cmd_trk_cmp_arb #(
  parameter int N     = 4,
  parameter int TAG_W = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       req,
  input  logic [N*TAG_W-1:0] tags,
  input  logic               en,
  output logic [N-1:0]       grant,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [TAG_W-1:0]   sel_tag
);

  always_comb begin
    grant   = '0;
    any     = 1'b0;
    idx     = '0;
    sel_tag = '0;
    if (en) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (req[i]) begin
          any     = 1'b1;
          idx     = IDX_W'(i);
          sel_tag = tags[i*TAG_W +: TAG_W];
        end
      end
    end
    if (any) grant[idx] = 1'b1;
  end

endmodule

// File: rtl/cmd_tracker.sv
module cmd_tracker
  import cmd_trk_pkg::*;
#(
  parameter int NUM_TAGS = 8,
  parameter int PAY_W    = 16,
  parameter int SQ_DEPTH = 4,
  parameter int CQ_DEPTH = 2,
  localparam int TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sub_valid,
  output logic                     sub_ready,
  input  logic [1:0]               sub_kind,
  input  logic [PAY_W-1:0]         sub_payload,
  output logic [NUM_ENG-1:0]       eng_valid,
  input  logic [NUM_ENG-1:0]       eng_ready,
  output logic [TAG_W-1:0]         eng_tag,
  output logic [PAY_W-1:0]         eng_payload,
  input  logic [NUM_ENG-1:0]       cmp_valid,
  input  logic [NUM_ENG*TAG_W-1:0] cmp_tag,
  output logic [NUM_ENG-1:0]       cmp_ready,
  output logic                     cq_valid,
  input  logic                     cq_ready,
  output logic [TAG_W-1:0]         cq_tag,
  output logic [1:0]               cq_eng,
  output logic                     ev_submit,
  output logic [TAG_W-1:0]         ev_submit_tag,
  output logic                     ev_dispatch,
  output logic [TAG_W-1:0]         ev_dispatch_tag,
  output logic                     ev_complete,
  output logic [TAG_W-1:0]         ev_complete_tag
);

  localparam int SQ_W = ENG_W + TAG_W + PAY_W;
  localparam int CQ_W = ENG_W + TAG_W;

  // submission side
  logic             free_any;
  logic [TAG_W-1:0] free_tag;
  logic             sq_full, sq_nonempty, sub_fire, disp_fire;
  logic [SQ_W-1:0]  sq_din, sq_dout;
  logic [ENG_W-1:0] head_kind;
  logic [TAG_W-1:0] head_tag;
  logic [PAY_W-1:0] head_pay;

  assign sub_ready = free_any && !sq_full;
  assign sub_fire  = sub_valid && sub_ready;
  assign sq_din    = {sub_kind, free_tag, sub_payload};
  assign {head_kind, head_tag, head_pay} = sq_dout;

  cmd_trk_fifo #(.W(SQ_W), .DEPTH(SQ_DEPTH)) u_subq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (sub_fire),
    .din      (sq_din),
    .pop      (disp_fire),
    .dout     (sq_dout),
    .full     (sq_full),
    .nonempty (sq_nonempty)
  );

  // dispatch to the engine queues
  assign eng_valid   = sq_nonempty ? (NUM_ENG'(1) << head_kind) : '0;
  assign eng_tag     = head_tag;
  assign eng_payload = head_pay;
  assign disp_fire   = sq_nonempty && eng_ready[head_kind];

  // completion collection
  logic             stg_valid_q, stg_valid_d;
  logic [TAG_W-1:0] stg_tag_q, stg_tag_d;
  logic [ENG_W-1:0] stg_eng_q, stg_eng_d;
  logic             cq_full, cq_push, cq_pop, arb_en, gnt_any;
  logic [ENG_W-1:0] gnt_idx;
  logic [TAG_W-1:0] gnt_tag;
  logic [CQ_W-1:0]  cq_dout;

  assign cq_push = stg_valid_q && !cq_full;
  assign arb_en  = !stg_valid_q || cq_push;

  cmd_trk_cmp_arb #(.N(NUM_ENG), .TAG_W(TAG_W)) u_arb (
    .req     (cmp_valid),
    .tags    (cmp_tag),
    .en      (arb_en),
    .grant   (cmp_ready),
    .any     (gnt_any),
    .idx     (gnt_idx),
    .sel_tag (gnt_tag)
  );

  always_comb begin
    stg_valid_d = stg_valid_q;
    stg_tag_d   = stg_tag_q;
    stg_eng_d   = stg_eng_q;
    if (gnt_any) begin
      stg_valid_d = 1'b1;
      stg_tag_d   = gnt_tag;
      stg_eng_d   = gnt_idx;
    end else if (cq_push) begin
      stg_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_valid_q <= 1'b0;
      stg_tag_q   <= '0;
      stg_eng_q   <= '0;
    end else begin
      stg_valid_q <= stg_valid_d;
      stg_tag_q   <= stg_tag_d;
      stg_eng_q   <= stg_eng_d;
    end
  end

  assign cq_pop = cq_valid && cq_ready;

  cmd_trk_fifo #(.W(CQ_W), .DEPTH(CQ_DEPTH)) u_cmplq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (cq_push),
    .din      ({stg_eng_q, stg_tag_q}),
    .pop      (cq_pop),
    .dout     (cq_dout),
    .full     (cq_full),
    .nonempty (cq_valid)
  );

  assign {cq_eng, cq_tag} = cq_dout;

  // inflight table
  cmd_trk_table #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (sub_fire),
    .alloc_eng (sub_kind),
    .free_any  (free_any),
    .free_tag  (free_tag),
    .issue_en  (disp_fire),
    .issue_tag (head_tag),
    .done_en   (gnt_any),
    .done_tag  (gnt_tag),
    .done_eng  (gnt_idx),
    .rel_en    (cq_push),
    .rel_tag   (stg_tag_q)
  );

  // trace strobes
  assign ev_submit       = sub_fire;
  assign ev_submit_tag   = free_tag;
  assign ev_dispatch     = disp_fire;
  assign ev_dispatch_tag = head_tag;
  assign ev_complete     = cq_push;
  assign ev_complete_tag = stg_tag_q;

  // R3
  eng_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_valid));

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_prio
    localparam logic [NUM_ENG-1:0] LOW_MASK = NUM_ENG'((1 << g) - 1);
    // R6
    grant_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_ready[g] |-> (cmp_valid[g] && ((cmp_valid & LOW_MASK) == '0)));
  end

  // R8
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_valid_q && !cq_push) |=> (stg_valid_q && $stable(stg_tag_q)));

  // R7
  publish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cq_push |=> cq_valid);

endmodule

// File: tb/cmd_tracker_test.sv
module cmd_tracker_test;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] pay;
    logic [2:0]  tag;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 16'h1A00, 3'd0},
    '{2'd1, 16'h1A11, 3'd1},
    '{2'd2, 16'h1A22, 3'd2},
    '{2'd3, 16'h1A33, 3'd3},
    '{2'd0, 16'h1A44, 3'd4},
    '{2'd2, 16'h1A55, 3'd5},
    '{2'd1, 16'h1A66, 3'd6},
    '{2'd3, 16'h1A77, 3'd7}
  };

  logic        clk, rst_n;
  logic        sub_valid, sub_ready;
  logic [1:0]  sub_kind;
  logic [15:0] sub_payload;
  logic [3:0]  eng_valid, eng_ready;
  logic [2:0]  eng_tag;
  logic [15:0] eng_payload;
  logic [3:0]  cmp_valid, cmp_ready;
  logic [11:0] cmp_tag;
  logic        cq_valid, cq_ready;
  logic [2:0]  cq_tag;
  logic [1:0]  cq_eng;
  logic        ev_submit, ev_dispatch, ev_complete;
  logic [2:0]  ev_submit_tag, ev_dispatch_tag, ev_complete_tag;

  int checks = 0;
  int fails  = 0;

  cmd_tracker uut (
    .clk(clk), .rst_n(rst_n),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_kind(sub_kind), .sub_payload(sub_payload),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_tag(eng_tag), .eng_payload(eng_payload),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_ready(cmp_ready),
    .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_tag(cq_tag), .cq_eng(cq_eng),
    .ev_submit(ev_submit), .ev_submit_tag(ev_submit_tag),
    .ev_dispatch(ev_dispatch), .ev_dispatch_tag(ev_dispatch_tag),
    .ev_complete(ev_complete), .ev_complete_tag(ev_complete_tag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sub_valid = 1'b0; sub_kind = '0; sub_payload = '0;
    eng_ready = '0; cmp_valid = '0; cmp_tag = '0; cq_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready in reset", 32'(sub_ready), 32'd1);
    chk("R1 cq_valid in reset", 32'(cq_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sub_ready", 32'(sub_ready), 32'd1);
    chk("R1 eng_valid", 32'(eng_valid), 32'd0);
    chk("R1 cmp_ready", 32'(cmp_ready), 32'd0);
    chk("R1 strobes", 32'({ev_submit, ev_dispatch, ev_complete}), 32'd0);

    // vector walk: submit and dispatch, tags accumulate (R2, R3)
    eng_ready = 4'hF;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sub_valid = 1'b1; sub_kind = VECS[i].kind; sub_payload = VECS[i].pay;
      #1;
      chk("R2 ev_submit", 32'(ev_submit), 32'd1);
      chk("R2 submit tag", 32'(ev_submit_tag), 32'(VECS[i].tag));
      @(negedge clk);
      sub_valid = 1'b0;
      #1;
      chk("R3 eng_valid", 32'(eng_valid), 32'(4'b0001 << VECS[i].kind));
      chk("R3 eng_tag", 32'(eng_tag), 32'(VECS[i].tag));
      chk("R3 eng_payload", 32'(eng_payload), 32'(VECS[i].pay));
      chk("R3 ev_dispatch", 32'({ev_dispatch, ev_dispatch_tag}), 32'({1'b1, VECS[i].tag}));
    end
    chk("R5 table full stalls", 32'(sub_ready), 32'd0);

    // simultaneous completions, completion FIFO not drained (R6, R7, R8)
    @(negedge clk);
    cmp_valid = 4'b1110;
    cmp_tag = {3'd3, 3'd2, 3'd1, 3'd0};
    #1;
    chk("R6 lowest index wins", 32'(cmp_ready), 32'b0010);
    @(negedge clk);
    cmp_valid = 4'b1100;
    #1;
    chk("R7 ev_complete tag1", 32'({ev_complete, ev_complete_tag}), 32'({1'b1, 3'd1}));
    chk("R6 next grant", 32'(cmp_ready), 32'b0100);
    chk("R7 tag not yet free", 32'(sub_ready), 32'd0);
    @(negedge clk);
    cmp_valid = 4'b1000;
    #1;
    chk("R7 ev_complete tag2", 32'({ev_complete, ev_complete_tag}), 32'({1'b1, 3'd2}));
    chk("R6 third grant", 32'(cmp_ready), 32'b1000);
    chk("R7 tag1 freed", 32'(sub_ready), 32'd1);
    chk("R7 first record", 32'({cq_valid, cq_eng, cq_tag}), 32'({1'b1, 2'd1, 3'd1}));
    @(negedge clk);
    cmp_valid = 4'b0001;
    #1;
    chk("R8 no publish while full", 32'(ev_complete), 32'd0);
    chk("R8 events held off", 32'(cmp_ready), 32'd0);

    // refill freed tags with head-of-line blocking (R4, R8)
    eng_ready = 4'b1011;
    @(negedge clk);
    sub_valid = 1'b1; sub_kind = 2'd2; sub_payload = 16'h3C01;
    #1;
    chk("R8 reuse tag1", 32'(ev_submit_tag), 32'd1);
    @(negedge clk);
    sub_kind = 2'd0; sub_payload = 16'h3C02;
    #1;
    chk("R8 reuse tag2", 32'(ev_submit_tag), 32'd2);
    @(negedge clk);
    sub_valid = 1'b0;
    #1;
    chk("R8 held tag3 stays occupied", 32'(sub_ready), 32'd0);
    chk("R4 blocked head only", 32'(eng_valid), 32'b0100);
    chk("R4 head payload", 32'(eng_payload), 32'h3C01);
    chk("R8 still held", 32'(cmp_ready), 32'd0);
    @(negedge clk);
    eng_ready = 4'hF;
    #1;
    chk("R4 head goes first", 32'({eng_valid, eng_tag}), 32'({4'b0100, 3'd1}));
    @(negedge clk);
    #1;
    chk("R4 then younger", 32'({eng_valid, eng_tag}), 32'({4'b0001, 3'd2}));

    // drain completion FIFO (R7, R8)
    @(negedge clk);
    cq_ready = 1'b1;
    #1;
    chk("R7 pop order 1", 32'({cq_eng, cq_tag}), 32'({2'd1, 3'd1}));
    @(negedge clk);
    #1;
    chk("R7 pop order 2", 32'({cq_eng, cq_tag}), 32'({2'd2, 3'd2}));
    chk("R8 staged tag3 published", 32'({ev_complete, ev_complete_tag}), 32'({1'b1, 3'd3}));
    chk("R6 dma event taken", 32'(cmp_ready), 32'b0001);
    @(negedge clk);
    cmp_valid = 4'b0000;
    #1;
    chk("R7 pop order 3", 32'({cq_eng, cq_tag}), 32'({2'd3, 3'd3}));
    chk("R7 ev_complete tag0", 32'({ev_complete, ev_complete_tag}), 32'({1'b1, 3'd0}));
    @(negedge clk);
    #1;
    chk("R7 pop order 4", 32'({cq_valid, cq_eng, cq_tag}), 32'({1'b1, 2'd0, 3'd0}));
    @(negedge clk);
    #1;
    chk("R7 queue empty", 32'(cq_valid), 32'd0);

    finish_run();
  end

endmodule